// File: doc/BRIEF.md
# Descriptor-driven configuration DMA engine

This block moves the bytes of a configuration item into system memory under the control of a descriptor held in memory. Software gives it the 64-bit address of a descriptor through a small register window. The address can be written as two 32-bit halves or as one 64-bit word, and the transfer begins when the address is complete. The engine reads a 16-byte big-endian descriptor. The descriptor carries a control word, a byte count and a target address.

The control word can first select a new item by key. It then either copies item bytes to the target or skips over them, and both move the shared item offset forward. Past the end of the item, or when no valid item is selected, a copy writes zeros. When the transfer ends, the engine writes a 32-bit status back over the control word. The item store and the key selection logic belong to the neighbouring read port. Here they appear only as a select strobe, an advance strobe, an availability flag and a data byte. A read of the register window returns an 8-byte identification signature.

Top module: `cfg_dma_engine`

## Requirements
- R1: A 4-byte write at window offset 0 loads address bits 63:32. A 4-byte write at offset 4 loads bits 31:0 and starts a transfer. An 8-byte write at offset 0 loads the whole address and starts a transfer.
- R2: Writes of any other size or offset are ignored, and so are all writes made while `busy` is high. The held address returns to zero at the moment a transfer starts, so a later low-half write alone uses a high half of zero.
- R3: The descriptor is fetched as 16 single-byte reads from the base address upward. It is big-endian: control word in bytes 0-3, length in bytes 4-7, target address in bytes 8-15. A memory request stays asserted with a stable address until it is acknowledged.
- R4: The control bits are: error = bit 0, copy = bit 1, skip = bit 2, select = bit 3. With select set, the engine pulses `item_sel` once with key = control bits 31:16, after the fetch and before any data moves, and the item offset returns to 0.
- R5: If neither copy nor skip is set, no data is written to memory and the item offset does not change.
- R6: A copy writes `length` bytes to ascending target addresses. While the item has bytes left, each byte is the item byte at the current offset, and the offset then goes up by one. After the item is exhausted, or when the selected key is invalid, the remaining bytes are 0x00. Copy takes priority when both copy and skip are set.
- R7: A skip advances the item offset by the lesser of the length and the bytes left in the item, and writes nothing to the target.
- R8: An error response on a descriptor read ends the fetch, and the status becomes 0x00000001. An error response on a data write stops the transfer with status 0x00000001, and the failed byte does not advance the offset.
- R9: On completion, the 32-bit status is written big-endian into descriptor bytes 0-3. It is 0 on success and 1 on error. `busy` is high from the cycle after the starting write until the last write-back byte is acknowledged.
- R10: `reg_rdata` returns the bytes of the signature 0x51454D5520434647 (most significant byte at offset 0). For a size of 1, 2, 4 or 8 bytes at the given offset, the selected bytes are right-aligned. Any other size, or a slice that runs past byte 7, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_off | input | 3 | Byte offset within the window |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature slice for the current offset and size |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completion carries an error (valid with ack) |
| mem_rdata | input | 8 | Read byte (valid with ack) |
| item_sel | output | 1 | Select strobe to the item store |
| item_key | output | 16 | Key to select |
| item_adv | output | 1 | Advance the item offset by one |
| item_avail | input | 1 | Current item has a byte at the current offset |
| item_data | input | 8 | Item byte at the current offset |

## Verification
Some rules are checked by the in-module assertions on every cycle. These cover the request hold rule, advancing only while a byte is available, selection only right after the fetch, skip issuing no memory traffic, clearing of the address at start, the address holding while busy, and busy ending only on an acknowledged write. The byte contents belong to the bench's scenarios, which compare memory and the item offset against a behavioural model after each descriptor. These are zero fill past the item end, invalid keys, skip then copy, the no-mode case, error status on fetch and on write, rejected write shapes, writes during busy and the signature slices.

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter logic [63:0] SIGNATURE = 64'h51454D5520434647
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_off,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [7:0]  mem_rdata,
  output logic        item_sel,
  output logic [15:0] item_key,
  output logic        item_adv,
  input  logic        item_avail,
  input  logic [7:0]  item_data
);
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECIDE, S_MOVE, S_WB} state_t;

  state_t      st;
  logic [63:0] addr_q, base, tgt;
  logic [31:0] ctrl, len;
  logic [3:0]  cnt;
  logic        errf;

  logic wr_hi, wr_lo, wr_full, start;
  logic [63:0] new_addr;

  assign wr_hi    = reg_wr && reg_size == 4'd4 && reg_off == 3'd0;
  assign wr_lo    = reg_wr && reg_size == 4'd4 && reg_off == 3'd4;
  assign wr_full  = reg_wr && reg_size == 4'd8 && reg_off == 3'd0;
  assign busy     = st != S_IDLE;
  assign start    = !busy && (wr_lo || wr_full);
  assign new_addr = wr_full ? reg_wdata : {addr_q[63:32], reg_wdata[31:0]};

  logic       size_ok;
  logic [6:0] lsh, rsh;
  logic [63:0] sig_shift;
  assign size_ok   = (reg_size == 4'd1 || reg_size == 4'd2 || reg_size == 4'd4 || reg_size == 4'd8)
                     && ({1'b0, reg_off} + reg_size) <= 4'd8;
  assign lsh       = {1'b0, reg_off, 3'b000};
  assign rsh       = 7'd64 - {reg_size[3:0], 3'b000};
  assign sig_shift = (SIGNATURE << lsh) >> rsh;
  assign reg_rdata = size_ok ? sig_shift : 64'd0;

  logic moving, copy_mode;
  assign copy_mode = ctrl[1];
  assign moving    = st == S_MOVE && len != 32'd0;

  assign mem_req   = st == S_FETCH || st == S_WB || (moving && copy_mode);
  assign mem_we    = st != S_FETCH;
  assign mem_addr  = st == S_MOVE ? tgt : base + {60'd0, cnt};
  assign mem_wdata = st == S_WB ? ((cnt == 4'(STAT_BYTES - 1)) ? {7'd0, errf} : 8'd0)
                                : (item_avail ? item_data : 8'd0);
  assign item_sel  = st == S_DECIDE && ctrl[3];
  assign item_key  = ctrl[31:16];
  assign item_adv  = moving && item_avail && (copy_mode ? (mem_ack && !mem_err) : ctrl[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= 64'd0;
      base   <= 64'd0;
      tgt    <= 64'd0;
      ctrl   <= 32'd0;
      len    <= 32'd0;
      cnt    <= 4'd0;
      errf   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            base   <= new_addr;
            addr_q <= 64'd0;
            errf   <= 1'b0;
            cnt    <= 4'd0;
            st     <= S_FETCH;
          end else if (wr_hi) begin
            addr_q[63:32] <= reg_wdata[31:0];
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (mem_err) begin
              errf <= 1'b1;
              cnt  <= 4'd0;
              st   <= S_WB;
            end else begin
              {ctrl, len, tgt} <= {ctrl[23:0], len, tgt, mem_rdata};
              cnt <= cnt + 4'd1;
              if (cnt == 4'(DESC_BYTES - 1)) begin
                cnt <= 4'd0;
                st  <= S_DECIDE;
              end
            end
          end
        end
        S_DECIDE: begin
          if (!ctrl[1] && !ctrl[2]) len <= 32'd0;
          st <= S_MOVE;
        end
        S_MOVE: begin
          if (len == 32'd0) begin
            cnt <= 4'd0;
            st  <= S_WB;
          end else if (copy_mode) begin
            if (mem_ack) begin
              if (mem_err) begin
                errf <= 1'b1;
                cnt  <= 4'd0;
                st   <= S_WB;
              end else begin
                tgt <= tgt + 64'd1;
                len <= len - 32'd1;
              end
            end
          end else begin
            len <= item_avail ? len - 32'd1 : 32'd0;
          end
        end
        S_WB: begin
          if (mem_ack) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'(STAT_BYTES - 1)) begin
              cnt <= 4'd0;
              st  <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_q == 64'd0); // R2
  AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(addr_q)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3
  AST_SEL_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    item_sel |-> $past(st) == S_FETCH); // R4
  AST_ADV_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    item_adv |-> item_avail); // R6
  AST_SKIP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_MOVE && !ctrl[1] |-> !mem_req); // R7
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_ack) && $past(mem_we)); // R9
endmodule

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic reg_wr = 0; logic [2:0] reg_off = 0; logic [3:0] reg_size = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic busy, mem_req, mem_we, mem_ack, mem_err, item_sel, item_adv, item_avail;
  logic [63:0] mem_addr; logic [7:0] mem_wdata, mem_rdata, item_data;
  logic [15:0] item_key;

  cfg_dma_engine u_dut (.*);

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // item store shared with the read port (modelled here)
  logic [15:0] st_key; logic [31:0] st_off;
  function automatic int ilen(input logic [15:0] k);
    case (k) 16'd0: return 4; 16'd1: return 8; 16'd2: return 6; 16'd3: return 3; default: return 0; endcase
  endfunction
  function automatic logic [7:0] ibyte(input logic [15:0] k, input int o);
    return 8'((k * 16 + o * 3 + 1) & 255);
  endfunction
  assign item_avail = st_off < 32'(ilen(st_key));
  assign item_data  = ibyte(st_key, int'(st_off));
  always @(posedge clk)
    if (!rst_n) begin st_key <= 0; st_off <= 0; end
    else if (item_sel) begin st_key <= item_key; st_off <= 0; end
    else if (item_adv) st_off <= st_off + 1;

  // memory: reads fail in 0x9000..0x90FF, writes fail in 0xA000..0xA0FF
  logic [7:0] mem [logic [63:0]];
  function automatic logic [7:0] rdm(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  always @(posedge clk) begin
    mem_ack <= 0; mem_err <= 0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack <= 1;
      if (mem_we) begin
        if (mem_addr >= 64'hA000 && mem_addr <= 64'hA0FF) mem_err <= 1;
        else mem[mem_addr] = mem_wdata;
      end else begin
        mem_rdata <= rdm(mem_addr);
        mem_err <= mem_addr >= 64'h9000 && mem_addr <= 64'h90FF;
      end
    end
  end

  // reference model of the item position
  int m_key = 0, m_off = 0;

  // per-clock comparison against model-level invariants
  always @(negedge clk) if (rst_n) begin
    if (mem_req && !busy) chk(0, "R9 request while idle", mem_req, 0);
    if (item_adv && !item_avail) chk(0, "R6 advance past item end", st_off, ilen(st_key));
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic regw(input logic [2:0] o, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_off = o; reg_size = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  task automatic put32(input logic [63:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[31 - 8*i -: 8];
  endtask
  function automatic logic [31:0] get32(input logic [63:0] a);
    return {rdm(a), rdm(a + 1), rdm(a + 2), rdm(a + 3)};
  endfunction

  // mode: 0 two halves, 1 single 64-bit, 2 low half only
  task automatic xfer(input string tag, input logic [63:0] d, input logic [31:0] c, input int n,
                      input logic [63:0] t, input int mode, input logic [63:0] intr);
    logic [7:0] exp [$];
    logic [31:0] est;
    bit fetch_err, wr_err;
    put32(d, c); put32(d + 4, n); put32(d + 8, t[63:32]); put32(d + 12, t[31:0]);
    for (int i = 0; i <= n; i++) mem[t + i] = 8'hAA;
    fetch_err = d >= 64'h9000 && d <= 64'h90FF;
    wr_err = t >= 64'hA000 && t <= 64'hA0FF;
    est = 0;
    if (fetch_err) est = 1;
    else begin
      if (c[3]) begin m_key = c[31:16]; m_off = 0; end
      for (int i = 0; i < n; i++) begin
        if (c[1]) begin
          if (wr_err) begin est = 1; break; end
          if (m_off < ilen(16'(m_key))) begin exp.push_back(ibyte(16'(m_key), m_off)); m_off++; end
          else exp.push_back(8'h00);
        end else if (c[2]) begin
          if (m_off < ilen(16'(m_key))) m_off++;
        end
      end
    end
    if (mode == 0) regw(3'd0, 4'd4, {32'd0, d[63:32]});
    if (mode == 1) regw(3'd0, 4'd8, d); else regw(3'd4, 4'd4, {32'd0, d[31:0]});
    chk(busy == 1, {tag, " R9 busy after start"}, busy, 1);
    if (intr != 0) begin regw(3'd0, 4'd8, intr); end
    wait_idle();
    for (int i = 0; i < n; i++) begin
      if (c[1] && !wr_err && !fetch_err) begin
        if (rdm(t + i) != exp[i]) chk(0, {tag, " R6 data byte"}, rdm(t + i), exp[i]);
      end else if (!wr_err) begin
        if (rdm(t + i) != 8'hAA) chk(0, {tag, " R5 R7 target touched"}, rdm(t + i), 8'hAA);
      end
    end
    chk(rdm(t + n) == 8'hAA, {tag, " R6 no write past length"}, rdm(t + n), 8'hAA);
    chk(get32(d) == est, {tag, " R8 R9 status word"}, get32(d), est);
    chk(st_off == 32'(m_off) && st_key == 16'(m_key), {tag, " R4 R7 item offset"}, st_off, m_off);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R9 reset idle", busy, 0);
    reg_off = 0; reg_size = 8; #1 chk(reg_rdata == 64'h51454D5520434647, "R10 full signature", reg_rdata, 64'h51454D5520434647);
    reg_off = 4; reg_size = 4; #1 chk(reg_rdata == 64'h20434647, "R10 low word", reg_rdata, 64'h20434647);
    reg_off = 0; reg_size = 2; #1 chk(reg_rdata == 64'h5145, "R10 first half-word", reg_rdata, 64'h5145);
    reg_off = 7; reg_size = 1; #1 chk(reg_rdata == 64'h47, "R10 last byte", reg_rdata, 64'h47);
    reg_off = 6; reg_size = 4; #1 chk(reg_rdata == 64'h0, "R10 out of window", reg_rdata, 0);
    reg_off = 1; reg_size = 3; #1 chk(reg_rdata == 64'h0, "R10 bad size", reg_rdata, 0);

    xfer("R1 R6 select+copy", 64'h1_0000_0100, {16'd1, 16'h000A}, 5, 64'h2000, 0, 0);
    xfer("R2 low half only, zero fill", 64'h0000_0300, 32'h0000_0002, 6, 64'h2100, 2, 0);
    xfer("R7 select+skip", 64'h0400, {16'd2, 16'h000C}, 3, 64'h2200, 1, 0);
    xfer("R6 copy after skip", 64'h0500, 32'h0000_0006, 4, 64'h2300, 1, 0);
    xfer("R5 no mode", 64'h0600, {16'd3, 16'h0008}, 10, 64'h2400, 1, 0);
    xfer("R6 invalid key", 64'h0700, {16'd9, 16'h000A}, 4, 64'h2500, 0, 0);
    xfer("R7 skip beyond item", 64'h0800, {16'd0, 16'h000C}, 9, 64'h2600, 1, 0);
    xfer("R8 fetch error", 64'h9000, {16'd1, 16'h000A}, 4, 64'h2700, 1, 0);
    xfer("R8 write error", 64'h0900, {16'd1, 16'h000A}, 4, 64'hA000, 1, 0);
    put32(64'h0C00, 32'h1234_5678);
    xfer("R2 write while busy", 64'h0B00, {16'd1, 16'h000A}, 6, 64'h2800, 1, 64'h0C00);
    repeat (60) @(negedge clk);
    chk(get32(64'h0C00) == 32'h1234_5678 && !busy, "R2 busy write ignored", get32(64'h0C00), 32'h1234_5678);

    regw(3'd0, 4'd2, 64'h0C00);
    regw(3'd2, 4'd4, 64'h0C00);
    regw(3'd4, 4'd8, 64'h0C00);
    repeat (3) @(negedge clk);
    chk(!busy && get32(64'h0C00) == 32'h1234_5678, "R2 rejected write shapes", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule